// File: doc/BRIEF.md
# Six-Stage Pipeline Hazard Controller

This block tracks instruction tokens through an in-order pipeline of six stages: fetch, decode, address generation, operand fetch, execute and write-back. Each token carries a program-counter tag, an optional destination register, one or two source registers, a branch marker, a taken flag and a target address. The controller moves every token forward by one stage on each clock. It holds the front of the pipe when a read-after-write dependency exists, and it clears wrong-path work when a taken branch resolves.

Fetch presents an address on `fetch_pc`. The surrounding logic returns the token fields for that address on the `in_*` inputs during the same cycle, and stage 1 captures them on the next edge. Branches resolve in execute (stage 5). A taken branch invalidates the four younger stages and steers fetch to its target. A consumer in operand fetch waits while the instruction in execute writes one of its sources. The outputs are the valid bit and tag of each stage, together with a retire strobe and the retired tag. There is no datapath and no bypass network.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears every stage valid bit and sets `fetch_pc` to zero. `retire` stays low on the first cycle after reset is released.
- R2: When the pipe neither holds nor redirects, `fetch_pc` rises by exactly one per clock, starting from zero.
- R3: Without a hazard, each valid token moves one stage per clock. The token fetched on the first edge after reset appears at `retire` after the sixth edge.
- R4: A held token stays in operand fetch (stage 4) for one cycle. It is held when that token has a valid source equal to the valid destination of the token in execute (stage 5). While it is held, stages 1 to 4 and `fetch_pc` keep their values, a bubble enters stage 5, and the producer moves on to stage 6.
- R5: A token in stage 5 with both branch and taken set causes three effects. `fetch_pc` shows its target in that same cycle. On the next edge stages 2 to 4 become bubbles, stage 1 takes the target, and the branch moves to stage 6. Four empty retire slots then separate the branch from the target.
- R6: A branch that is not taken in stage 5 invalidates nothing. Its target has no effect on `fetch_pc`.
- R7: A taken branch in stage 5 wins over a simultaneous dependency hold. The pipe redirects and does not freeze.
- R8: `retire` is high exactly when stage 6 holds a valid token, and `retire_pc` then gives that token's tag. Bubbles never raise `retire`.
- R9: Every source slot, including the second one, is compared against the destination in stage 5. A producer two slots ahead of its consumer causes no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_dst_vld | input | 1 | Fetched token writes a register |
| in_dst | input | RA_W | Destination register of the fetched token |
| in_src_vld | input | NUM_SRC | Per-slot source-used flags, slot 0 in bit 0 |
| in_src | input | NUM_SRC*RA_W | Source registers, slot s in bits [s*RA_W +: RA_W] |
| in_is_br | input | 1 | Fetched token is a branch |
| in_br_taken | input | 1 | Branch outcome, used when it reaches stage 5 |
| in_br_tgt | input | PC_W | Branch target address |
| fetch_pc | output | PC_W | Address being fetched this cycle |
| stg_vld | output | 6 | Valid bit per stage, bit 0 = fetch, bit 5 = write-back |
| stg_pc | output | 6*PC_W | Tag per stage, stage i in bits [i*PC_W +: PC_W] |
| retire | output | 1 | A valid token leaves stage 6 |
| retire_pc | output | PC_W | Tag of the token leaving stage 6 |

## Verification
The assertions assume that `rst` is held for at least one edge before any token matters. They also assume that the `in_*` fields are stable around each rising edge and describe the address that `fetch_pc` presented in that cycle. The bench keeps to this by driving the fields from a small program function of `fetch_pc` on each falling edge, after the address has settled. The program contains an adjacent dependency, a dependency two slots apart, a dependency on the second source, a not-taken branch, and a taken branch whose wrong-path successor depends on it.

// File: rtl/phc_pkg.sv
package phc_pkg;
   localparam int PHC_STAGES = 6;
   localparam int STG_FETCH  = 0;
   localparam int STG_DECODE = 1;
   localparam int STG_AGEN   = 2;
   localparam int STG_OPND   = 3;
   localparam int STG_EXEC   = 4;
   localparam int STG_WB     = 5;
endpackage

// File: rtl/phc_fetch.sv
module phc_fetch #(
   parameter int PC_W = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            hold,
   input  logic            redirect,
   input  logic [PC_W-1:0] tgt,
   output logic [PC_W-1:0] fetch_pc
);
   logic [PC_W-1:0] pc_q;

   assign fetch_pc = redirect ? tgt : pc_q;

   always_ff @(posedge clk) begin
      if (rst)        pc_q <= '0;
      else if (!hold) pc_q <= fetch_pc + PC_W'(1);
   end

   assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
      (!hold && !redirect) |=> (pc_q == $past(pc_q) + PC_W'(1)));
   assert_redirect_R5: assert property (@(posedge clk) disable iff (rst)
      redirect |=> (pc_q == $past(tgt) + PC_W'(1)));
   assert_hold_pc_R4: assert property (@(posedge clk) disable iff (rst)
      (hold && !redirect) |=> $stable(pc_q));
endmodule

// File: rtl/phc_hazard.sv
module phc_hazard #(
   parameter int RA_W    = 5,
   parameter int NUM_SRC = 2
) (
   input  logic                           opnd_vld,
   input  logic [NUM_SRC-1:0]             opnd_src_v,
   input  logic [NUM_SRC-1:0][RA_W-1:0]   opnd_src,
   input  logic                           exec_vld,
   input  logic                           exec_dst_v,
   input  logic [RA_W-1:0]                exec_dst,
   input  logic                           exec_br,
   input  logic                           exec_tk,
   output logic                           squash,
   output logic                           stall
);
   logic [NUM_SRC-1:0] hit;
   logic               raw;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
      assign hit[s] = opnd_src_v[s] && (opnd_src[s] == exec_dst);
   end

   assign raw    = opnd_vld && exec_vld && exec_dst_v && (|hit);
   assign squash = exec_vld && exec_br && exec_tk;
   assign stall  = raw && !squash;

   always_comb begin
      assert_one_action_R7: assert (!(squash && stall));
   end
endmodule

// File: rtl/phc_stage_array.sv
module phc_stage_array
   import phc_pkg::*;
#(
   parameter int TOK_W = 8
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  hold,
   input  logic                                  squash,
   input  logic [TOK_W-1:0]                      fetch_tok,
   output logic [PHC_STAGES-1:0]                 vld_q,
   output logic [PHC_STAGES-1:0][TOK_W-1:0]      tok_q
);
   for (genvar i = 0; i < PHC_STAGES; i++) begin : g_stg
      logic             v_q;
      logic [TOK_W-1:0] t_q;
      assign vld_q[i] = v_q;
      assign tok_q[i] = t_q;

      if (i == STG_FETCH) begin : g_head
         always_ff @(posedge clk) begin
            if (rst) v_q <= 1'b0;
            else if (!hold) v_q <= 1'b1;
            if (!hold) t_q <= fetch_tok;
         end
      end else if (i < STG_EXEC) begin : g_front
         always_ff @(posedge clk) begin
            if (rst || squash) v_q <= 1'b0;
            else if (!hold)    v_q <= vld_q[i-1];
            if (!hold) t_q <= tok_q[i-1];
         end
      end else if (i == STG_EXEC) begin : g_bubble
         always_ff @(posedge clk) begin
            if (rst) v_q <= 1'b0;
            else     v_q <= vld_q[i-1] && !squash && !hold;
            t_q <= tok_q[i-1];
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (rst) v_q <= 1'b0;
            else     v_q <= vld_q[i-1];
            t_q <= tok_q[i-1];
         end
      end
   end

   assert_squash_clears_R5: assert property (@(posedge clk) disable iff (rst)
      (squash && !rst) |=> (vld_q[STG_OPND:STG_DECODE] == '0) && vld_q[STG_FETCH]
                           && !vld_q[STG_EXEC] && vld_q[STG_WB]);
   assert_hold_freezes_R4: assert property (@(posedge clk) disable iff (rst)
      (hold && !rst) |=> $stable(vld_q[STG_OPND:STG_FETCH]) && $stable(tok_q[STG_OPND])
                         && !vld_q[STG_EXEC]);
   assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
      (!hold && !squash && !rst) |=> (vld_q[STG_EXEC] == $past(vld_q[STG_OPND]))
                                     && (vld_q[STG_WB] == $past(vld_q[STG_EXEC])));
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
   import phc_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int RA_W    = 5,
   parameter int NUM_SRC = 2
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        in_dst_vld,
   input  logic [RA_W-1:0]             in_dst,
   input  logic [NUM_SRC-1:0]          in_src_vld,
   input  logic [NUM_SRC*RA_W-1:0]     in_src,
   input  logic                        in_is_br,
   input  logic                        in_br_taken,
   input  logic [PC_W-1:0]             in_br_tgt,
   output logic [PC_W-1:0]             fetch_pc,
   output logic [PHC_STAGES-1:0]       stg_vld,
   output logic [PHC_STAGES*PC_W-1:0]  stg_pc,
   output logic                        retire,
   output logic [PC_W-1:0]             retire_pc
);
   if (PC_W < 2 || PC_W > 64) begin : g_bad_pc
      $error("pipe_hazard_ctrl: PC_W out of range");
   end
   if (RA_W < 1 || RA_W > 8) begin : g_bad_ra
      $error("pipe_hazard_ctrl: RA_W out of range");
   end
   if (NUM_SRC < 1 || NUM_SRC > 2) begin : g_bad_src
      $error("pipe_hazard_ctrl: NUM_SRC must be 1 or 2");
   end

   typedef struct packed {
      logic [PC_W-1:0]                tgt;
      logic                           tk;
      logic                           br;
      logic [NUM_SRC-1:0][RA_W-1:0]   src;
      logic [NUM_SRC-1:0]             src_v;
      logic [RA_W-1:0]                dst;
      logic                           dst_v;
      logic [PC_W-1:0]                pc;
   } tok_t;

   localparam int TOK_W = $bits(tok_t);

   tok_t                               new_tok, opnd_tok, exec_tok;
   logic [PHC_STAGES-1:0][TOK_W-1:0]   stg_tok;
   logic                               squash, stall;
   logic                               unused_fields;

   assign new_tok.tgt   = in_br_tgt;
   assign new_tok.tk    = in_br_taken;
   assign new_tok.br    = in_is_br;
   assign new_tok.src   = in_src;
   assign new_tok.src_v = in_src_vld;
   assign new_tok.dst   = in_dst;
   assign new_tok.dst_v = in_dst_vld;
   assign new_tok.pc    = fetch_pc;

   assign opnd_tok = tok_t'(stg_tok[STG_OPND]);
   assign exec_tok = tok_t'(stg_tok[STG_EXEC]);

   phc_hazard #(.RA_W(RA_W), .NUM_SRC(NUM_SRC)) u_hazard (
      .opnd_vld   (stg_vld[STG_OPND]),
      .opnd_src_v (opnd_tok.src_v),
      .opnd_src   (opnd_tok.src),
      .exec_vld   (stg_vld[STG_EXEC]),
      .exec_dst_v (exec_tok.dst_v),
      .exec_dst   (exec_tok.dst),
      .exec_br    (exec_tok.br),
      .exec_tk    (exec_tok.tk),
      .squash     (squash),
      .stall      (stall)
   );

   phc_fetch #(.PC_W(PC_W)) u_fetch (
      .clk      (clk),
      .rst      (rst),
      .hold     (stall),
      .redirect (squash),
      .tgt      (exec_tok.tgt),
      .fetch_pc (fetch_pc)
   );

   phc_stage_array #(.TOK_W(TOK_W)) u_stages (
      .clk       (clk),
      .rst       (rst),
      .hold      (stall),
      .squash    (squash),
      .fetch_tok (new_tok),
      .vld_q     (stg_vld),
      .tok_q     (stg_tok)
   );

   for (genvar i = 0; i < PHC_STAGES; i++) begin : g_tag
      tok_t t;
      assign t = tok_t'(stg_tok[i]);
      assign stg_pc[i*PC_W +: PC_W] = t.pc;
   end

   assign retire        = stg_vld[STG_WB];
   assign retire_pc     = stg_pc[STG_WB*PC_W +: PC_W];
   assign unused_fields = ^stg_tok;

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!retire && (stg_vld[STG_WB:STG_DECODE] == '0)));
   assert_retire_follows_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(stg_vld[STG_EXEC])) |-> !retire);
endmodule

// File: tb/pipe_hazard_ctrl_tb.sv
module pipe_hazard_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PC_W = 8;
   localparam int RA_W = 4;
   localparam int NSRC = 2;

   // {retire expected, retire_pc expected} after edge e (index e-1)
   localparam logic [8:0] RET_TBL [24] = '{
      9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h100, 9'h101, 9'h000,
      9'h102, 9'h103, 9'h104, 9'h105, 9'h000, 9'h000, 9'h000, 9'h000,
      9'h114, 9'h115, 9'h116, 9'h117, 9'h000, 9'h118, 9'h119, 9'h11A};

   logic                  clk = 1'b0;
   logic                  rst = 1'b1;
   logic                  in_dst_vld;
   logic [RA_W-1:0]       in_dst;
   logic [NSRC-1:0]       in_src_vld;
   logic [NSRC*RA_W-1:0]  in_src;
   logic                  in_is_br, in_br_taken;
   logic [PC_W-1:0]       in_br_tgt;
   logic [PC_W-1:0]       fetch_pc;
   logic [5:0]            stg_vld;
   logic [6*PC_W-1:0]     stg_pc;
   logic                  retire;
   logic [PC_W-1:0]       retire_pc;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pipe_hazard_ctrl #(.PC_W(PC_W), .RA_W(RA_W), .NUM_SRC(NSRC)) u_dut (
      .clk(clk), .rst(rst), .in_dst_vld(in_dst_vld), .in_dst(in_dst),
      .in_src_vld(in_src_vld), .in_src(in_src), .in_is_br(in_is_br),
      .in_br_taken(in_br_taken), .in_br_tgt(in_br_tgt), .fetch_pc(fetch_pc),
      .stg_vld(stg_vld), .stg_pc(stg_pc), .retire(retire), .retire_pc(retire_pc));

   // Program: token fields for each address
   task automatic drive(input logic [PC_W-1:0] pc);
      in_dst_vld = 0; in_dst = '0; in_src_vld = '0; in_src = '0;
      in_is_br = 0; in_br_taken = 0; in_br_tgt = '0;
      case (pc)
         8'd1:  begin in_dst_vld = 1; in_dst = 4'd1; end
         8'd2:  begin in_src_vld = 2'b01; in_src = {4'd0, 4'd1}; end
         8'd4:  begin in_is_br = 1; in_br_taken = 0; in_br_tgt = 8'd40; end
         8'd5:  begin in_is_br = 1; in_br_taken = 1; in_br_tgt = 8'd20;
                      in_dst_vld = 1; in_dst = 4'd2; end
         8'd6:  begin in_src_vld = 2'b01; in_src = {4'd0, 4'd2}; end
         8'd20: begin in_dst_vld = 1; in_dst = 4'd3; end
         8'd22: begin in_src_vld = 2'b10; in_src = {4'd3, 4'd0}; end
         8'd23: begin in_dst_vld = 1; in_dst = 4'd4; end
         8'd24: begin in_src_vld = 2'b10; in_src = {4'd4, 4'd0}; end
         default: ;
      endcase
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic string row_tag(input int e);
      if (e == 8)             return "R4 bubble after hold";
      if (e >= 13 && e <= 16) return "R5 branch penalty slot";
      if (e == 21)            return "R9 second-source bubble";
      if (e == 19)            return "R9 no hold two slots apart";
      return "R3 R8 retire sequence";
   endfunction

   initial begin
      #(CLK_PERIOD * 10000);
      n_chk++; n_fail++;
      $display("FAIL watchdog R3: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      drive('0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset valid", 32'(stg_vld), 32'h0);
      chk("R1 reset fetch", 32'(fetch_pc), 32'h0);
      chk("R1 reset retire", 32'(retire), 32'h0);
      rst = 0;
      drive(fetch_pc);

      for (int e = 1; e <= 24; e++) begin
         @(posedge clk);
         @(negedge clk);
         chk(row_tag(e), 32'(retire), 32'(RET_TBL[e-1][8]));
         if (RET_TBL[e-1][8]) chk(row_tag(e), 32'(retire_pc), 32'(RET_TBL[e-1][7:0]));
         if (e == 7) begin
            chk("R4 fetch held", 32'(fetch_pc), 32'd6);
            chk("R4 stage valids in hold", 32'(stg_vld), 32'b101111);
         end
         if (e == 8)  chk("R2 sequential fetch", 32'(fetch_pc), 32'd7);
         if (e == 10) chk("R6 not-taken target ignored", 32'(fetch_pc), 32'd9);
         if (e == 11) begin
            chk("R6 no squash on not-taken", 32'(stg_vld), 32'b111111);
            chk("R5 R7 redirect shown", 32'(fetch_pc), 32'd20);
         end
         if (e == 12) begin
            chk("R5 R7 squash valids", 32'(stg_vld), 32'b100001);
            chk("R5 target in fetch stage", 32'(stg_pc[PC_W-1:0]), 32'd20);
            chk("R2 R7 fetch after redirect", 32'(fetch_pc), 32'd21);
         end
         drive(fetch_pc);
      end

      rst = 1;
      @(posedge clk);
      @(negedge clk);
      chk("R1 mid-run reset valid", 32'(stg_vld), 32'h0);
      chk("R1 mid-run reset fetch", 32'(fetch_pc), 32'h0);
      chk("R1 mid-run reset retire", 32'(retire), 32'h0);
      rst = 0;
      drive(fetch_pc);
      for (int k = 1; k <= 6; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k == 1) chk("R1 no retire after reset", 32'(retire), 32'h0);
         if (k == 6) begin
            chk("R3 six-cycle latency", 32'(retire), 32'h1);
            chk("R3 first tag", 32'(retire_pc), 32'h0);
         end
         drive(fetch_pc);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule